// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block keeps the running state of one DMA channel: a 16-bit current address, a 16-bit current transfer count and a page register. Software, or a register front end outside this block, loads a base address and a base count. Each accepted transfer strobe then moves the address up by one unit and the count down by one. The block combines the page register with the current address to present a physical byte address. It also reports how many bytes are still to be moved.

A parameter selects the channel width. A byte channel places the full page above the 16-bit address, so each page is a 64K-byte window. A word channel moves 16 bits per transfer. It shifts the address left by one and drops page bit 0, so each page is a 128K-byte window and every address is even. The page never increments, so an address that overflows wraps inside its window. The count is held as the number of transfers minus one. Terminal count is signalled on the strobe that takes the count from zero to 0xFFFF. At that point the channel either reloads its base values (auto-initialise) or masks itself until it is loaded again.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is masked (`chan_masked_o`=1), the current address, count and page are zero, the physical address reads 0, and the residue reads 1 for a byte channel and 2 for a word channel.
- R2: A load copies the base address and base count into the current address and count, records the auto-initialise choice and clears the mask, all visible on the cycle after the load.
- R3: Each strobe accepted while unmasked adds one to the current address and subtracts one from the current count. An accepted strobe is one with `xfer_i`=1, `load_i`=0 and the channel unmasked.
- R4: In byte mode the physical address is {page[7:0], addr[15:0]}.
- R5: In word mode the physical address is {page[7:1], addr[15:0], 0}. Page bit 0 has no effect and bit 0 of the physical address is always 0.
- R6: When the current address rolls over from 0xFFFF to 0x0000, the page field of the physical address does not change.
- R7: A loaded count C yields exactly C+1 accepted strobes up to and including terminal count. `tc_o` is high during the strobe in which the count is 0x0000, and only then.
- R8: The residue reads (count+1) mod 65536 in a byte channel and twice that value in a word channel. After a completed transfer without auto-initialise it reads 0.
- R9: Without auto-initialise the channel masks itself after terminal count. While masked, strobes do not change the address, the count or the physical address, and `tc_o` stays low.
- R10: With auto-initialise, terminal count reloads the current address and count from the base values and the channel stays unmasked.
- R11: A page write changes only the page field of the physical address from the next cycle on. It leaves the current address and count unchanged.
- R12: A load that arrives together with a strobe wins: the strobe is not accepted and `tc_o` stays low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load base values into the current registers |
| base_addr_i | input | 16 | Base address to load |
| base_cnt_i | input | 16 | Base count to load (transfers minus one) |
| auto_init_i | input | 1 | Auto-initialise selection, captured on load |
| page_we_i | input | 1 | Page register write enable |
| page_i | input | 8 | Page value to write |
| xfer_i | input | 1 | Transfer strobe |
| phys_addr_o | output | 24 | Physical byte address of the current transfer |
| residue_o | output | 16 (byte) / 17 (word) | Bytes remaining |
| tc_o | output | 1 | Terminal count, valid during the accepted strobe |
| chan_masked_o | output | 1 | Channel masked and ignoring strobes |

## Verification
The hardest condition to reach from the ports is a terminal count at the largest possible count: 65536 transfers. This run must also carry the address across its 16-bit rollover and still hold `tc_o` low until the very last strobe. The bench loads 0xFFFF with a start address in the upper half of the window and issues every strobe back to back, checking `tc_o` on each one. The smaller counts are swept individually. The case where a load and a strobe arrive in the same cycle is set up deliberately: the channel is first left holding count zero, so a strobe that was wrongly accepted would show up at once as a terminal count.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic {
      SIZE_BYTE = 1'b0,
      SIZE_WORD = 1'b1
   } xfer_size_e;

   // width of the byte residue: one extra bit when each transfer is two bytes
   function automatic int residue_width(input int addr_w, input xfer_size_e sz);
      return (sz == SIZE_WORD) ? addr_w + 1 : addr_w;
   endfunction

endpackage

// File: rtl/dma_chan_state.sv
module dma_chan_state #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [ADDR_W-1:0] base_cnt_i,
   input  logic              auto_init_i,
   input  logic              xfer_i,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic [ADDR_W-1:0] cur_cnt_o,
   output logic              masked_o,
   output logic              auto_o,
   output logic              tc_o
);

   logic [ADDR_W-1:0] base_addr_q, base_cnt_q, addr_q, cnt_q;
   logic              auto_q, mask_q;
   logic              accept, at_zero;

   assign accept  = xfer_i && !load_i && !mask_q;
   assign at_zero = (cnt_q == '0);
   assign tc_o    = accept && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr_q <= '0;
         base_cnt_q  <= '0;
         addr_q      <= '0;
         cnt_q       <= '0;
         auto_q      <= 1'b0;
         mask_q      <= 1'b1;
      end else if (load_i) begin
         base_addr_q <= base_addr_i;
         base_cnt_q  <= base_cnt_i;
         addr_q      <= base_addr_i;
         cnt_q       <= base_cnt_i;
         auto_q      <= auto_init_i;
         mask_q      <= 1'b0;
      end else if (accept) begin
         if (at_zero && auto_q) begin
            addr_q <= base_addr_q;
            cnt_q  <= base_cnt_q;
         end else begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
            if (at_zero) mask_q <= 1'b1;
         end
      end
   end

   assign cur_addr_o = addr_q;
   assign cur_cnt_o  = cnt_q;
   assign masked_o   = mask_q;
   assign auto_o     = auto_q;

endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
   import dma_seq_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         PAGE_W    = 8,
   parameter xfer_size_e XFER_SIZE = SIZE_BYTE,
   localparam int        PHYS_W    = ADDR_W + PAGE_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PAGE_W-1:0] page_i,
   output logic [PHYS_W-1:0] phys_o
);

   generate
      if (XFER_SIZE == SIZE_WORD) begin : g_word
         logic unused_page_lsb;
         assign unused_page_lsb = page_i[0];
         assign phys_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
      end else begin : g_byte
         assign phys_o = {page_i, addr_i};
      end
   endgenerate

endmodule

// File: rtl/dma_residue_calc.sv
module dma_residue_calc
   import dma_seq_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter xfer_size_e XFER_SIZE = SIZE_BYTE,
   localparam int        RES_W     = residue_width(ADDR_W, XFER_SIZE)
) (
   input  logic [ADDR_W-1:0] cnt_i,
   output logic [RES_W-1:0]  residue_o
);

   logic [ADDR_W-1:0] left;
   assign left = cnt_i + 1'b1;

   generate
      if (XFER_SIZE == SIZE_WORD) begin : g_word
         assign residue_o = {left, 1'b0};
      end else begin : g_byte
         assign residue_o = left;
      end
   endgenerate

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         PAGE_W    = 8,
   parameter xfer_size_e XFER_SIZE = SIZE_BYTE,
   localparam int        PHYS_W    = ADDR_W + PAGE_W,
   localparam int        RES_W     = residue_width(ADDR_W, XFER_SIZE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [ADDR_W-1:0] base_cnt_i,
   input  logic              auto_init_i,
   input  logic              page_we_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              xfer_i,
   output logic [PHYS_W-1:0] phys_addr_o,
   output logic [RES_W-1:0]  residue_o,
   output logic              tc_o,
   output logic              chan_masked_o
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dma_chan_seq: ADDR_W must be at least 2");
      end
      if (PAGE_W < 2) begin : g_bad_page
         $error("dma_chan_seq: PAGE_W must be at least 2");
      end
   endgenerate

   logic [PAGE_W-1:0] page_q;
   logic [ADDR_W-1:0] cur_addr, cur_cnt;
   logic              chan_auto;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         page_q <= '0;
      else if (page_we_i) page_q <= page_i;
   end

   dma_chan_state #(.ADDR_W(ADDR_W)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .base_addr_i (base_addr_i),
      .base_cnt_i  (base_cnt_i),
      .auto_init_i (auto_init_i),
      .xfer_i      (xfer_i),
      .cur_addr_o  (cur_addr),
      .cur_cnt_o   (cur_cnt),
      .masked_o    (chan_masked_o),
      .auto_o      (chan_auto),
      .tc_o        (tc_o)
   );

   dma_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .XFER_SIZE(XFER_SIZE)) u_map (
      .addr_i (cur_addr),
      .page_i (page_q),
      .phys_o (phys_addr_o)
   );

   dma_residue_calc #(.ADDR_W(ADDR_W), .XFER_SIZE(XFER_SIZE)) u_res (
      .cnt_i     (cur_cnt),
      .residue_o (residue_o)
   );

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int PHYS_W = 24,
   parameter int RES_W  = 16,
   parameter bit WORD   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [ADDR_W-1:0] base_cnt_i,
   input logic              xfer_i,
   input logic              page_we_i,
   input logic              tc_o,
   input logic              chan_masked_o,
   input logic [RES_W-1:0]  residue_o,
   input logic [PHYS_W-1:0] phys_addr_o,
   input logic              chan_auto
);

   localparam logic [RES_W-1:0] UNIT = WORD ? RES_W'(2) : RES_W'(1);

   logic [ADDR_W-1:0] load_left;
   logic [RES_W-1:0]  load_res;
   assign load_left = base_cnt_i + 1'b1;
   assign load_res  = WORD ? RES_W'({load_left, 1'b0}) : RES_W'(load_left);

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (!chan_masked_o && residue_o == $past(load_res)));

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !load_i && !chan_masked_o && !tc_o) |=>
         (residue_o == $past(residue_o) - UNIT));

   assert_tc_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tc_o |-> (residue_o == UNIT));

   assert_tc_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_o && !chan_auto) |=> chan_masked_o);

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chan_masked_o |-> !tc_o);

   assert_masked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_masked_o && !load_i && !page_we_i) |=>
         ($stable(phys_addr_o) && $stable(residue_o)));

   assert_autoreload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_o && chan_auto) |=> !chan_masked_o);

   assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !tc_o);

endmodule

bind dma_chan_seq dma_chan_seq_chk #(
   .ADDR_W (ADDR_W),
   .PHYS_W (PHYS_W),
   .RES_W  (RES_W),
   .WORD   (XFER_SIZE == dma_seq_pkg::SIZE_WORD)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .load_i        (load_i),
   .base_cnt_i    (base_cnt_i),
   .xfer_i        (xfer_i),
   .page_we_i     (page_we_i),
   .tc_o          (tc_o),
   .chan_masked_o (chan_masked_o),
   .residue_o     (residue_o),
   .phys_addr_o   (phys_addr_o),
   .chan_auto     (chan_auto)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
   import dma_seq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [15:0] base_addr = '0;
   logic [15:0] base_cnt = '0;
   logic        auto_init = 1'b0;
   logic        page_we = 1'b0;
   logic [7:0]  page_in = '0;
   logic        xfer = 1'b0;

   logic [23:0] phys_b, phys_w;
   logic [15:0] res_b;
   logic [16:0] res_w;
   logic        tc_b, tc_w, mask_b, mask_w;

   always #10 clk = ~clk;

   dma_chan_seq #(.XFER_SIZE(SIZE_BYTE)) u_dut (
      .clk(clk), .rst_n(rst_n), .load_i(load), .base_addr_i(base_addr),
      .base_cnt_i(base_cnt), .auto_init_i(auto_init), .page_we_i(page_we),
      .page_i(page_in), .xfer_i(xfer), .phys_addr_o(phys_b),
      .residue_o(res_b), .tc_o(tc_b), .chan_masked_o(mask_b));

   dma_chan_seq #(.XFER_SIZE(SIZE_WORD)) u_dut_w (
      .clk(clk), .rst_n(rst_n), .load_i(load), .base_addr_i(base_addr),
      .base_cnt_i(base_cnt), .auto_init_i(auto_init), .page_we_i(page_we),
      .page_i(page_in), .xfer_i(xfer), .phys_addr_o(phys_w),
      .residue_o(res_w), .tc_o(tc_w), .chan_masked_o(mask_w));

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [15:0] m_addr = '0, m_cnt = '0, m_baddr = '0, m_bcnt = '0;
   logic [7:0]  m_page = '0;
   logic        m_auto = 1'b0, m_mask = 1'b1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare_state(input string req);
      logic [15:0] left;
      left = m_cnt + 16'd1;
      chk(req, 32'(phys_b), 32'({m_page, m_addr}));
      chk(req, 32'(phys_w), 32'({m_page[7:1], m_addr, 1'b0}));
      chk(req, 32'(res_b), 32'(left));
      chk(req, 32'(res_w), 32'({left, 1'b0}));
      chk(req, 32'(mask_b), 32'(m_mask));
      chk(req, 32'(mask_w), 32'(m_mask));
   endtask

   task automatic do_load(input logic [15:0] a, input logic [15:0] c, input logic au);
      @(negedge clk);
      load = 1'b1; base_addr = a; base_cnt = c; auto_init = au;
      @(posedge clk); #1;
      load = 1'b0;
      m_addr = a; m_cnt = c; m_baddr = a; m_bcnt = c; m_auto = au; m_mask = 1'b0;
   endtask

   task automatic do_page(input logic [7:0] p);
      @(negedge clk);
      page_we = 1'b1; page_in = p;
      @(posedge clk); #1;
      page_we = 1'b0;
      m_page = p;
   endtask

   // one strobe; tc is checked while the strobe is held, before the edge
   task automatic do_xfer(input string req, input bit full);
      logic exp_tc;
      @(negedge clk);
      xfer = 1'b1;
      #1;
      exp_tc = !m_mask && (m_cnt == 16'd0);
      chk(req, 32'(tc_b), 32'(exp_tc));
      chk(req, 32'(tc_w), 32'(exp_tc));
      @(posedge clk); #1;
      xfer = 1'b0;
      if (!m_mask) begin
         if (m_cnt == 16'd0 && m_auto) begin
            m_addr = m_baddr; m_cnt = m_bcnt;
         end else begin
            if (m_cnt == 16'd0) m_mask = 1'b1;
            m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
         end
      end
      if (full) compare_state(req);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      compare_state("R1");
      rst_n = 1'b1;
      @(posedge clk); #1;
      compare_state("R1");
      // R9: strobes while masked from reset are ignored
      do_xfer("R9", 1'b1);

      // R11/R4/R5: page write, odd page so word mode must drop bit 0
      do_page(8'h35);
      compare_state("R11");

      // R2/R3/R7/R8/R9: sweep of small counts without auto-initialise
      foreach (m_page[i]) begin end
      for (int k = 0; k < 8; k++) begin
         logic [15:0] c;
         c = (k < 6) ? 16'(k) : ((k == 6) ? 16'd37 : 16'd255);
         do_load(16'h0100 + 16'(k * 16'h0333), c, 1'b0);
         compare_state("R2");
         for (int n = 0; n <= int'(c); n++) do_xfer("R7", 1'b1);
         chk("R8", 32'(res_b), 32'd0);
         chk("R8", 32'(res_w), 32'd0);
         for (int n = 0; n < 3; n++) do_xfer("R9", 1'b1);
      end

      // R6: address rollover keeps the page field
      do_page(8'hA6);
      do_load(16'hFFFD, 16'd5, 1'b0);
      for (int n = 0; n < 6; n++) do_xfer("R6", 1'b1);
      chk("R6", 32'(phys_b[23:16]), 32'h0000_00A6);

      // R10: auto-initialise reload, two full rounds
      do_load(16'h1234, 16'd2, 1'b1);
      for (int n = 0; n < 7; n++) do_xfer("R10", 1'b1);
      chk("R10", 32'(mask_b), 32'd0);

      // R12: load and strobe together while the count is zero
      do_load(16'h4000, 16'd0, 1'b0);
      @(negedge clk);
      load = 1'b1; xfer = 1'b1; base_addr = 16'h5555; base_cnt = 16'd9; auto_init = 1'b0;
      #1;
      chk("R12", 32'(tc_b), 32'd0);
      chk("R12", 32'(tc_w), 32'd0);
      @(posedge clk); #1;
      load = 1'b0; xfer = 1'b0;
      m_addr = 16'h5555; m_cnt = 16'd9; m_baddr = 16'h5555; m_bcnt = 16'd9;
      m_auto = 1'b0; m_mask = 1'b0;
      compare_state("R12");

      // R11: page write mid-transfer leaves address and count alone
      do_xfer("R3", 1'b1);
      do_page(8'h5B);
      compare_state("R11");
      do_xfer("R11", 1'b1);

      // R7: largest count, 65536 strobes across the address rollover
      do_page(8'h12);
      do_load(16'h8000, 16'hFFFF, 1'b0);
      compare_state("R2");
      for (int n = 0; n < 65536; n++) do_xfer("R7", (n % 1024 == 0) || (n > 65530));
      compare_state("R8");
      chk("R8", 32'(res_b), 32'd0);
      do_xfer("R9", 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule